// File: doc/BRIEF.md
# Reference Switchover Controller

This block watches two redundant reference clocks from a stable local clock and picks which one feeds the downstream phase detector. Each reference goes through a two-flop synchronizer. A shared timer cuts local time into windows of a programmable number of cycles. At the end of each window, a reference that showed no rising edge during the window is flagged as lost. A lost reference must show edges in several consecutive windows before it counts as usable again, which keeps a marginal input from chattering in and out of use.

The selection runs in automatic or manual mode. In automatic mode a revertive policy always goes back to the preferred reference once that reference has requalified. A nonrevertive policy stays on the current reference for as long as it stays good. When no usable reference remains, the controller freezes the select line and raises a holdover flag, so the downstream loop can coast. In manual mode the manual select pin alone sets the choice, and holdover reflects only the health of the reference in use. Every change of the select line is followed by a guard interval of at least one window.

All pins are plain level signals: there is no data stream and no handshake. The mode and length inputs are expected to be quasi-static.

Top module: `ref_switch_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, sel is 0 (reference A), lost is 2'b11 and holdover is 1.
- R2: lost[0] belongs to reference A (ref_in[0]) and lost[1] to reference B (ref_in[1]). A flag sets at the end of a window of win_len local cycles in which the synchronized reference showed no rising edge, and it never sets within 10 cycles of the reference going quiet when win_len is 16.
- R3: A set loss flag clears only after qual_windows consecutive windows that each contain a rising edge. A window with no edge restarts the count, so a reference that has been back for fewer windows than that stays flagged.
- R4: In automatic revertive mode (auto_mode=1, revertive=1), sel equals pref_sel (0=A, 1=B) whenever that reference is not lost. Otherwise sel moves to the other reference if that one is not lost.
- R5: In automatic nonrevertive mode (revertive=0), sel stays on the current reference while it is not lost, even if pref_sel differs. sel moves to the other reference only when the current one is lost.
- R6: In automatic mode, holdover is 1 exactly when both references are lost, and sel keeps its value during holdover. As soon as either reference requalifies, holdover drops and sel follows the policy of R4 or R5.
- R7: In manual mode (auto_mode=0), sel follows man_sel. Loss flags keep updating, and holdover is 1 only while the reference currently driven on sel is lost.
- R8: After any change of sel, sel does not change again for at least win_len local cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local stable clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 2 | Reference activity, bit 0 = A, bit 1 = B (asynchronous) |
| win_len | input | WIN_W | Window length in local cycles (values below 2 act as 2) |
| qual_windows | input | QUAL_W | Good windows needed to requalify (0 acts as 1) |
| auto_mode | input | 1 | 1 = automatic selection, 0 = manual |
| revertive | input | 1 | 1 = return to the preferred reference when it is good |
| pref_sel | input | 1 | Preferred reference, 0 = A, 1 = B |
| man_sel | input | 1 | Manual choice, 0 = A, 1 = B |
| sel | output | 1 | Selected reference, 0 = A, 1 = B |
| lost | output | 2 | Per-reference loss flags, bit 0 = A, bit 1 = B |
| holdover | output | 1 | Holdover status |

## Verification
The hardest situation to reach is a reference that comes back and then falls silent again before it has requalified. The block must keep its flag and must not switch, even though edges are visibly present. The bench gates free-running asynchronous toggles on each reference and re-enables a lost reference for fewer windows than the requalification count. It samples the flag in that gap, then waits long enough for a real requalification. A second hard case is the guard interval. The bench flips the manual select every few cycles and measures the spacing of every select change it observes.

// File: rtl/ref_sw_pkg.sv
package ref_sw_pkg;
  localparam int NUM_REFS = 2;
  typedef logic [NUM_REFS-1:0] ref_vec_t;
  typedef enum logic {REF_A = 1'b0, REF_B = 1'b1} ref_id_t;
endpackage

// File: rtl/ref_win_timer.sv
module ref_win_timer #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_end
);
  localparam logic [WIN_W-1:0] MIN_LAST = WIN_W'(1);

  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W-1:0] last;

  // a window never shorter than two cycles
  assign last    = (win_len < WIN_W'(2)) ? MIN_LAST : (win_len - WIN_W'(1));
  assign win_end = (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (win_end) cnt_q <= '0;
    else              cnt_q <= cnt_q + WIN_W'(1);
  end

  // R2: window boundaries are isolated single-cycle pulses
  a_r2_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> !win_end);
endmodule

// File: rtl/ref_activity_mon.sv
module ref_activity_mon #(
  parameter int QUAL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_async,
  input  logic              win_end,
  input  logic [QUAL_W-1:0] qual_windows,
  output logic              lost
);
  logic [2:0]        sync_q;
  logic              edge_seen;
  logic              seen_q;
  logic              good_win;
  logic [QUAL_W-1:0] good_cnt_q;
  logic [QUAL_W-1:0] need;

  assign edge_seen = sync_q[1] & ~sync_q[2];
  assign good_win  = seen_q | edge_seen;
  assign need      = (qual_windows == '0) ? QUAL_W'(1) : qual_windows;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ref_async};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       seen_q <= 1'b0;
    else if (win_end) seen_q <= 1'b0;
    else if (edge_seen) seen_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lost       <= 1'b1;
      good_cnt_q <= '0;
    end else if (win_end) begin
      if (!good_win) begin
        lost       <= 1'b1;
        good_cnt_q <= '0;
      end else if (lost) begin
        if ((good_cnt_q + QUAL_W'(1)) >= need) begin
          lost       <= 1'b0;
          good_cnt_q <= '0;
        end else begin
          good_cnt_q <= good_cnt_q + QUAL_W'(1);
        end
      end
    end
  end

  // R2: loss is declared only on a window boundary
  a_r2_loss_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> $past(win_end));
  // R3: requalification completes only on a window boundary
  a_r3_clear_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lost) |-> $past(win_end));
endmodule

// File: rtl/ref_select_fsm.sv
module ref_select_fsm
  import ref_sw_pkg::*;
#(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ref_vec_t         lost,
  input  logic [WIN_W-1:0] win_len,
  input  logic             auto_mode,
  input  logic             revertive,
  input  logic             pref_sel,
  input  logic             man_sel,
  output logic             sel,
  output logic             holdover
);
  ref_id_t          sel_q;
  ref_id_t          target;
  logic             hold_next;
  logic [WIN_W-1:0] guard_q;
  logic             both_lost;
  logic             cur_ok;
  logic             pref_ok;

  assign both_lost = &lost;
  assign cur_ok    = ~lost[sel_q];
  assign pref_ok   = ~lost[pref_sel];

  always_comb begin
    target    = sel_q;
    hold_next = 1'b0;
    if (auto_mode) begin
      hold_next = both_lost;
      if (!both_lost) begin
        if (revertive) target = pref_ok ? ref_id_t'(pref_sel) : ref_id_t'(~pref_sel);
        else           target = cur_ok ? sel_q : ref_id_t'(~sel_q);
      end
    end else begin
      target    = ref_id_t'(man_sel);
      hold_next = ~cur_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= REF_A;
      guard_q <= '0;
    end else if (guard_q != '0) begin
      guard_q <= guard_q - WIN_W'(1);
    end else if (target != sel_q) begin
      sel_q   <= target;
      guard_q <= win_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) holdover <= 1'b1;
    else        holdover <= hold_next;
  end

  assign sel = sel_q;

  // R8: no change of selection while the guard interval runs
  a_r8_guard_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_q != '0) |=> $stable(sel_q));
  // R6: two lost references in automatic mode force holdover
  a_r6_holdover_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && (&lost)) |=> holdover);
  // R7: manual mode with a healthy selected reference is never in holdover
  a_r7_manual_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode && !lost[sel_q]) |=> !holdover);
endmodule

// File: rtl/ref_switch_ctrl.sv
module ref_switch_ctrl
  import ref_sw_pkg::*;
#(
  parameter int WIN_W  = 16,
  parameter int QUAL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ref_in,
  input  logic [WIN_W-1:0]  win_len,
  input  logic [QUAL_W-1:0] qual_windows,
  input  logic              auto_mode,
  input  logic              revertive,
  input  logic              pref_sel,
  input  logic              man_sel,
  output logic              sel,
  output logic [1:0]        lost,
  output logic              holdover
);
  logic     win_end;
  ref_vec_t lost_vec;

  ref_win_timer #(.WIN_W(WIN_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .win_len (win_len),
    .win_end (win_end)
  );

  for (genvar i = 0; i < NUM_REFS; i++) begin : g_mon
    ref_activity_mon #(.QUAL_W(QUAL_W)) u_mon (
      .clk          (clk),
      .rst_n        (rst_n),
      .ref_async    (ref_in[i]),
      .win_end      (win_end),
      .qual_windows (qual_windows),
      .lost         (lost_vec[i])
    );
  end

  ref_select_fsm #(.WIN_W(WIN_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .lost      (lost_vec),
    .win_len   (win_len),
    .auto_mode (auto_mode),
    .revertive (revertive),
    .pref_sel  (pref_sel),
    .man_sel   (man_sel),
    .sel       (sel),
    .holdover  (holdover)
  );

  assign lost = lost_vec;

  // R1: reset leaves both references unqualified
  a_r1_reset_lost: assert property (@(posedge clk)
    !rst_n |=> (lost == 2'b11));
endmodule

// File: tb/tb_ref_switch_ctrl.sv
module tb_ref_switch_ctrl;
  localparam int CLK_P  = 10;
  localparam int WIN_W  = 16;
  localparam int QUAL_W = 4;
  localparam int WIN    = 16;
  localparam int SETTLE = 12 * WIN;
  localparam int NVEC   = 12;

  // {en_a, en_b, auto, rev, pref, man, exp_sel, exp_lost[1:0], exp_hold}
  localparam logic [9:0] VEC [NVEC] = '{
    10'b11_1_1_0_0_0_00_0, // R4 both good, prefer A
    10'b01_1_1_0_0_1_01_0, // R4 A lost -> B
    10'b11_1_1_0_0_0_00_0, // R4 A back -> revert to A
    10'b11_1_0_1_0_0_00_0, // R5 nonrevertive stays on A
    10'b01_1_0_1_0_1_01_0, // R5 A lost -> B
    10'b11_1_0_0_0_1_00_0, // R5 A back, stay on B
    10'b00_1_0_0_0_1_11_1, // R6 both lost -> holdover, sel kept
    10'b10_1_0_0_0_0_10_0, // R6 A requalifies -> leave holdover on A
    10'b11_0_0_0_1_1_00_0, // R7 manual picks B
    10'b10_0_0_0_1_1_10_1, // R7 manual on lost B -> holdover
    10'b10_0_0_0_0_0_10_0, // R7 manual back to A
    10'b11_1_1_1_0_1_00_0  // R4 revert to preferred B
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_a = 1'b0, ref_b = 1'b0;
  logic en_a = 1'b0, en_b = 1'b0;
  logic [WIN_W-1:0] win_len = WIN_W'(WIN);
  logic [QUAL_W-1:0] qual_windows = QUAL_W'(3);
  logic auto_mode = 1'b1, revertive = 1'b1, pref_sel = 1'b0, man_sel = 1'b0;
  logic sel, holdover;
  logic [1:0] lost;
  int checks = 0, errors = 0;
  logic prev_sel = 1'b0;
  int since = 1000000;
  bit done = 1'b0;

  ref_switch_ctrl #(.WIN_W(WIN_W), .QUAL_W(QUAL_W)) dut (
    .clk(clk), .rst_n(rst_n), .ref_in({ref_b, ref_a}), .win_len(win_len),
    .qual_windows(qual_windows), .auto_mode(auto_mode), .revertive(revertive),
    .pref_sel(pref_sel), .man_sel(man_sel), .sel(sel), .lost(lost),
    .holdover(holdover)
  );

  always #(CLK_P/2) clk = ~clk;
  initial forever begin #7; if (en_a) ref_a = ~ref_a; end
  initial forever begin #9; if (en_b) ref_b = ~ref_b; end

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // R8: spacing between select changes
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sel !== prev_sel) begin
        checks++;
        if (since < WIN) begin
          errors++;
          $display("FAIL R8: select changed after %0d cycles, expected >= %0d", since, WIN);
        end
        since = 0;
      end else begin
        since++;
      end
      prev_sel = sel;
    end
  end

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(4);
    chk("R1 in reset", {sel, lost, holdover}, 4'b0111);
    rst_n = 1'b1;
    wait_cyc(1);
    chk("R1 after release", {sel, lost, holdover}, 4'b0111);

    for (int v = 0; v < NVEC; v++) begin
      {en_a, en_b, auto_mode, revertive, pref_sel, man_sel} = VEC[v][9:4];
      wait_cyc(SETTLE);
      chk($sformatf("R4-R7 vector %0d", v), {sel, lost, holdover}, VEC[v][3:0]);
    end

    // R2: loss is not declared early, and is declared within two windows
    en_b = 1'b0;
    wait_cyc(10);
    chk("R2 B not lost early", {3'b000, lost[1]}, 4'b0000);
    wait_cyc(40);
    chk("R2 B lost", {3'b000, lost[1]}, 4'b0001);

    // R3: a reference back for fewer than qual_windows windows stays lost
    en_b = 1'b1;
    wait_cyc(30);
    chk("R3 B still lost while requalifying", {3'b000, lost[1]}, 4'b0001);
    en_b = 1'b0;
    wait_cyc(40);
    en_b = 1'b1;
    wait_cyc(30);
    chk("R3 count restarted after a silent window", {3'b000, lost[1]}, 4'b0001);
    wait_cyc(80);
    chk("R3 B requalified", {3'b000, lost[1]}, 4'b0000);

    // R8: rapid manual toggling, spacing checked by the monitor
    auto_mode = 1'b0;
    for (int k = 0; k < 20; k++) begin
      man_sel = ~man_sel;
      wait_cyc(3);
    end
    man_sel = 1'b0;
    wait_cyc(3 * WIN);
    chk("R7 manual settles on A", {sel, lost, holdover}, 4'b0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule